// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a 12-bit sampling converter that returns its results serially. It drives an active-low chip select and a serial clock, and it reads one data line. Each conversion frame lasts sixteen serial clock periods. The returned stream starts with four bits that must be zero, followed by the twelve result bits, most significant bit first. The block captures the frame, checks the four leading bits, and publishes the 12-bit result together with a one-cycle valid strobe and a framing-error flag.

A frame starts when `start_i` is pulsed while the block is idle. It also starts repeatedly when free-running mode is enabled, with a programmable number of extra idle cycles between frames. The serial clock divider, the chip-select setup interval and the quiet interval between frames are all derived from parameters given in hertz and nanoseconds. The derived cycle counts are rounded up, so the serial clock never exceeds its maximum rate and neither interval is ever shortened.

Top module: `adc_rd_ctrl`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `cs_n_o` is 1, `sclk_o` is 1 and `valid_o` is 0.
- R2: A `start_i` pulse sampled while idle begins a frame, and `cs_n_o` falls on that clock edge. A `start_i` that arrives during a frame, in the cycle the frame completes, or during the quiet interval starts nothing.
- R3: Each frame has exactly 16 falling edges of `sclk_o`. Every low phase, and every high phase between two falling edges, lasts DIV system clocks, where DIV = ceil(SYS_HZ / (2 * SCLK_MAX_HZ)).
- R4: The first falling edge of `sclk_o` comes no sooner than SETUP clocks after `cs_n_o` falls, where SETUP = max(1, ceil(SETUP_NS * SYS_HZ / 1e9)).
- R5: Stream bit 1 is valid on `sdata_i` from the fall of `cs_n_o`, and bit k+1 is valid after falling edge k. Bit k is sampled at falling edge k. Stream bits 5 through 16 form `result_o[11:0]`, with bit 5 as bit 11.
- R6: `frame_err_o` is 1 exactly when at least one of stream bits 1 to 4 was read as 1. It is presented with the result of the same frame.
- R7: `valid_o` is high for a single cycle per frame, in the cycle that `cs_n_o` returns high after the sixteenth rising edge. `result_o` and `frame_err_o` change only in that cycle.
- R8: Between frames, `cs_n_o` stays high for at least QUIET = max(1, ceil(QUIET_NS * SYS_HZ / 1e9)) clocks. With `auto_en_i` set, the next frame begins after exactly QUIET + 1 + `auto_gap_i` clocks of `cs_n_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-frame request, honoured only while idle |
| auto_en_i | input | 1 | Free-running frame mode enable |
| auto_gap_i | input | GAP_W | Extra idle clocks between frames in free-running mode |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | DATA_W | Last 12-bit result |
| frame_err_o | output | 1 | Leading bits of the last frame were not all zero |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
Completing a frame and receiving a new request can fall in the same cycle: the final serial rising edge raises chip select and fires the valid strobe on the very edge where a host would naturally ask for the next sample. The bench drives `start_i` in the cycle right after it sees `valid_o`, which places the request on the completion and quiet path. It also sends another request in the middle of a running frame. It then counts chip-select falling edges over a long idle window and expects exactly one frame. In free-running mode it measures the chip-select high time between frames and compares it with the exact gap formula.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_QUIET = 2'd3
  } rd_state_e;

  // System clocks per serial clock half period, rounded up so the rate stays below the limit.
  function automatic int half_div(longint sys_hz, longint sclk_max_hz);
    longint d;
    d = (sys_hz + 2 * sclk_max_hz - 1) / (2 * sclk_max_hz);
    return (d < 1) ? 1 : int'(d);
  endfunction

  // Nanosecond interval expressed in system clocks, rounded up, at least one.
  function automatic int ns_cycles(longint ns, longint sys_hz);
    longint c;
    c = (ns * sys_hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD;
    end else if (!run || tick) begin
      cnt_q <= LOAD;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_shreg.sv
module adc_rd_shreg #(
  parameter int BITS = 16,
  parameter int DW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic          din,
  input  logic          done,
  output logic [DW-1:0] result,
  output logic          err,
  output logic          valid
);
  logic [BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      result <= '0;
      err    <= 1'b0;
      valid  <= 1'b0;
    end else begin
      if (shift) sh_q <= {sh_q[BITS-2:0], din};
      valid <= done;
      if (done) begin
        result <= sh_q[DW-1:0];
        err    <= |sh_q[BITS-1:DW];
      end
    end
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int BITS      = 16,
  parameter int SETUP_CYC = 1,
  parameter int QUIET_CYC = 5,
  parameter int GAP_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             auto_en_i,
  input  logic [GAP_W-1:0] auto_gap_i,
  input  logic             tick,
  output logic             run,
  output logic             cs_n,
  output logic             sclk,
  output logic             fall_ev,
  output logic             done_ev
);
  localparam int WMAX  = (SETUP_CYC > QUIET_CYC) ? SETUP_CYC : QUIET_CYC;
  localparam int WW    = $clog2(WMAX + 1);
  localparam int BW    = $clog2(BITS + 1);

  rd_state_e        st_q;
  logic [WW-1:0]    wait_q;
  logic [BW-1:0]    bit_q;
  logic [GAP_W-1:0] gap_q;
  logic             go, rise_ev;

  assign run     = (st_q == ST_SHIFT);
  assign fall_ev = run && tick && sclk;
  assign rise_ev = run && tick && !sclk;
  assign done_ev = rise_ev && (bit_q == BW'(BITS));
  assign go      = (st_q == ST_IDLE) && (start_i || (auto_en_i && gap_q >= auto_gap_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
      bit_q  <= '0;
      gap_q  <= '0;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (gap_q != '1) gap_q <= gap_q + 1'b1;
          if (go) begin
            cs_n   <= 1'b0;
            st_q   <= ST_SETUP;
            wait_q <= WW'(SETUP_CYC - 1);
          end
        end
        ST_SETUP: begin
          if (wait_q == '0) begin
            st_q  <= ST_SHIFT;
            bit_q <= '0;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) sclk <= !sclk;
          if (fall_ev) bit_q <= bit_q + 1'b1;
          if (done_ev) begin
            cs_n   <= 1'b1;
            st_q   <= ST_QUIET;
            wait_q <= WW'(QUIET_CYC - 1);
          end
        end
        ST_QUIET: begin
          if (wait_q == '0) begin
            st_q  <= ST_IDLE;
            gap_q <= '0;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter longint SYS_HZ      = 100_000_000,
  parameter longint SCLK_MAX_HZ = 18_000_000,
  parameter longint QUIET_NS    = 50,
  parameter longint SETUP_NS    = 10,
  parameter int     DATA_W      = 12,
  parameter int     LEAD_W      = 4,
  parameter int     GAP_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              auto_en_i,
  input  logic [GAP_W-1:0]  auto_gap_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              frame_err_o,
  output logic              valid_o
);
  localparam int FRAME_BITS = DATA_W + LEAD_W;
  localparam int DIV        = half_div(SYS_HZ, SCLK_MAX_HZ);
  localparam int QUIET_CYC  = ns_cycles(QUIET_NS, SYS_HZ);
  localparam int SETUP_CYC  = ns_cycles(SETUP_NS, SYS_HZ);

  // Named internal events, observed by the bound checker.
  logic run_w, tick_w, sclk_fall_w, frame_done_w;

  adc_rd_tick #(.DIV(DIV)) tick_i (
    .clk (clk),
    .rst_n (rst_n),
    .run (run_w),
    .tick (tick_w)
  );

  adc_rd_seq #(
    .BITS (FRAME_BITS),
    .SETUP_CYC (SETUP_CYC),
    .QUIET_CYC (QUIET_CYC),
    .GAP_W (GAP_W)
  ) seq_i (
    .clk (clk),
    .rst_n (rst_n),
    .start_i (start_i),
    .auto_en_i (auto_en_i),
    .auto_gap_i (auto_gap_i),
    .tick (tick_w),
    .run (run_w),
    .cs_n (cs_n_o),
    .sclk (sclk_o),
    .fall_ev (sclk_fall_w),
    .done_ev (frame_done_w)
  );

  adc_rd_shreg #(.BITS(FRAME_BITS), .DW(DATA_W)) shreg_i (
    .clk (clk),
    .rst_n (rst_n),
    .shift (sclk_fall_w),
    .din (sdata_i),
    .done (frame_done_w),
    .result (result_o),
    .err (frame_err_o),
    .valid (valid_o)
  );
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int DW        = 12,
  parameter int BITS      = 16,
  parameter int QUIET_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n_o,
  input logic          sclk_o,
  input logic          valid_o,
  input logic [DW-1:0] result_o,
  input logic          frame_err_o,
  input logic          sclk_fall_w,
  input logic          frame_done_w
);
  logic [15:0] hi_cnt;
  logic [7:0]  fall_cnt;
  logic        seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      fall_cnt   <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (cs_n_o) begin
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
        fall_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (sclk_fall_w) fall_cnt <= fall_cnt + 1'b1;
      end
      if (frame_done_w) seen_frame <= 1'b1;
    end
  end

  a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  a_r3_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_w |-> (fall_cnt == 8'(BITS)));

  a_r7_valid_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(result_o) && $stable(frame_err_o)));

  a_r8_quiet_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) && seen_frame) |-> (hi_cnt >= 16'(QUIET_CYC)));
endmodule

bind adc_rd_ctrl adc_rd_chk #(
  .DW (DATA_W),
  .BITS (FRAME_BITS),
  .QUIET_CYC (QUIET_CYC)
) chk_i (
  .clk (clk),
  .rst_n (rst_n),
  .cs_n_o (cs_n_o),
  .sclk_o (sclk_o),
  .valid_o (valid_o),
  .result_o (result_o),
  .frame_err_o (frame_err_o),
  .sclk_fall_w (sclk_fall_w),
  .frame_done_w (frame_done_w)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
  localparam longint SYS_HZ  = 250_000_000;
  localparam longint SCLK_HZ = 18_000_000;
  localparam longint Q_NS    = 50;
  localparam longint S_NS    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        auto_en_i = 1'b0;
  logic [15:0] auto_gap_i = '0;
  logic        sdata_i = 1'b0;
  logic        cs_n_o, sclk_o, frame_err_o, valid_o;
  logic [11:0] result_o;

  always #2 clk = ~clk;

  adc_rd_ctrl #(.SYS_HZ(SYS_HZ), .SCLK_MAX_HZ(SCLK_HZ), .QUIET_NS(Q_NS), .SETUP_NS(S_NS)) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .auto_en_i (auto_en_i),
    .auto_gap_i (auto_gap_i), .sdata_i (sdata_i), .cs_n_o (cs_n_o), .sclk_o (sclk_o),
    .result_o (result_o), .frame_err_o (frame_err_o), .valid_o (valid_o)
  );

  // Expected counts found by search, not by the design's closed form.
  function automatic int smallest_div();
    for (int d = 1; d < 1000; d++) if (2 * d * SCLK_HZ >= SYS_HZ) return d;
    return 0;
  endfunction
  function automatic int smallest_cyc(longint ns);
    for (int c = 1; c < 1000; c++) if (longint'(c) * 1_000_000_000 >= ns * SYS_HZ) return c;
    return 0;
  endfunction

  int div_e, quiet_e, setup_e;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Converter model: bit 1 on chip-select fall, next bit after each serial clock fall.
  logic [15:0] tx_word = '0;
  int tx_idx = 0;
  always @(negedge cs_n_o or negedge sclk_o) begin
    #1;
    if (sclk_o) begin
      sdata_i = tx_word[15];
      tx_idx = 1;
    end else if (!cs_n_o && tx_idx < 16) begin
      sdata_i = tx_word[15 - tx_idx];
      tx_idx++;
    end
  end

  // Pin monitor sampled away from the active edge.
  int  frames = 0, falls = 0, hi_run = 0, last_hi = 0, setup_run = 0, last_setup = 0;
  int  sclk_run = 0, width_bad = 0;
  bit  started = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b1; hi_run = 0;
    end else begin
      if (cs_n_o) hi_run++;
      else begin
        if (prev_cs) begin
          frames++; last_hi = hi_run; hi_run = 0; falls = 0;
          started = 0; setup_run = 0; sclk_run = 0;
        end
        if (sclk_o != prev_sclk) begin
          if (!prev_sclk && sclk_run != div_e) width_bad++;
          if (prev_sclk && started && sclk_run != div_e) width_bad++;
          if (prev_sclk) begin
            falls++;
            if (!started) last_setup = setup_run;
            started = 1;
          end
          sclk_run = 1;
        end else sclk_run++;
        if (!started) setup_run++;
      end
      prev_cs = cs_n_o; prev_sclk = sclk_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (valid_o) seen = 1;
    end
    if (!seen) check(0, "R7 valid timeout", 0, 1);
  endtask

  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h0ABC, 16'h0FFF, 16'h0000, 16'h0800, 16'h8123, 16'h1001};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    int f0;
    logic [11:0] held;
    div_e = smallest_div(); quiet_e = smallest_cyc(Q_NS); setup_e = smallest_cyc(S_NS);
    repeat (5) @(negedge clk);
    check(cs_n_o == 1'b1, "R1 cs_n reset", int'(cs_n_o), 1);
    check(sclk_o == 1'b1, "R1 sclk reset", int'(sclk_o), 1);
    check(valid_o == 1'b0, "R1 valid reset", int'(valid_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      tx_word = VEC[v];
      pulse_start();
      wait_valid(seen);
      check(result_o == VEC[v][11:0], "R5 result", int'(result_o), int'(VEC[v][11:0]));
      check(frame_err_o == (|VEC[v][15:12]), "R6 frame error", int'(frame_err_o), int'(|VEC[v][15:12]));
      check(falls == 16, "R3 falls per frame", falls, 16);
      check(last_setup >= setup_e, "R4 setup clocks", last_setup, setup_e);
      check(cs_n_o == 1'b1 && sclk_o == 1'b1, "R1 idle levels after frame", int'({cs_n_o, sclk_o}), 3);
      held = result_o;
      @(negedge clk);
      check(valid_o == 1'b0, "R7 single-cycle valid", int'(valid_o), 0);
      repeat (40) @(negedge clk);
      check(result_o == held, "R7 result held", int'(result_o), int'(held));
    end
    check(width_bad == 0, "R3 phase widths", width_bad, 0);

    // R2: requests mid-frame and on completion are ignored.
    f0 = frames;
    tx_word = 16'h0555;
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    wait_valid(seen);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (400) @(negedge clk);
    check(frames == f0 + 1, "R2 extra start ignored", frames - f0, 1);
    check(cs_n_o == 1'b1, "R2 idle after ignored start", int'(cs_n_o), 1);

    // R8: free-running gap.
    auto_gap_i = 16'd5; auto_en_i = 1'b1; tx_word = 16'h0321;
    wait_valid(seen);
    wait_valid(seen);
    check(last_hi == quiet_e + 1 + 5, "R8 auto gap 5", last_hi, quiet_e + 6);
    check(result_o == 12'h321, "R5 auto result", int'(result_o), 12'h321);
    auto_gap_i = 16'd0;
    wait_valid(seen);
    wait_valid(seen);
    auto_en_i = 1'b0;
    check(last_hi == quiet_e + 1, "R8 auto gap 0", last_hi, quiet_e + 1);
    check(last_hi >= quiet_e, "R8 quiet minimum", last_hi, quiet_e);
    repeat (300) @(negedge clk);
    check(width_bad == 0, "R3 phase widths auto", width_bad, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule